// File: doc/BRIEF.md
# Off-Time Valley Detector with Ringing Time-Out

This block runs during the off-time of a quasi-resonant power switch. It watches the digitised output of a zero-crossing comparator on the auxiliary winding and counts each downward crossing as one valley of the drain ringing. It ignores the comparator for a short window after each on-time, because the turn-off edge rings hard. The window is halved when the current set-point is at light load. When the ringing is too damped to cross the threshold, an internal time-out stands in for the missing valley. When the count reaches the valley number chosen by the selection logic, the block issues a one-cycle turn-on request after a fixed delay.

A second, independent timer watches the short-detect comparator. It raises a sticky fault flag when that comparator reports a low auxiliary voltage for too long. The timer is held off while the dimming input is below its enable level. Both comparators, the gate driver and the valley-selection logic sit outside the block and connect through plain ports. All durations are given in clock cycles.

Top module: `valley_timer`

## Requirements
- R1: A valley is counted when `zcd_hi` is 1 in one cycle and 0 in the next, while the block is armed. `valley_cnt` holds the number of valleys counted in the current off-time, starting at 1 for the first valley and saturating at its all-ones value.
- R2: Let the falling edge of `gate` be first seen in cycle f. Crossings are then ignored in cycle f and in the following BLANK_CYC cycles. The first cycle in which a crossing counts is f+BLANK_CYC+1.
- R3: `light_load` becomes 1 one cycle after `setpoint` is below LIGHT_ENTER. It becomes 0 one cycle after `setpoint` is above LIGHT_EXIT, and holds its value in between. If it is 1 when `gate` falls, the blanking length is BLANK_CYC/2.
- R4: While the block is armed and `zcd_hi` stays 0, a valley is inserted every TIMEOUT_CYC cycles without a new crossing. The count restarts after each counted crossing or inserted valley.
- R5: When the valley that makes the count equal `valley_sel` is counted in cycle k, `turn_on` is 1 for exactly the single cycle k+TURNON_DLY. This happens at most once per off-time, so later valleys do not repeat it. A `valley_sel` of 0 never matches.
- R6: A rising edge of `gate` clears `valley_cnt` to 0 in the following cycle and cancels any pending turn-on request.
- R7: `turn_on` is 0 in any cycle in which `sw_en` is 0.
- R8: When `dim_on` is 1 and `zsc_hi` is 0 for SHORT_CYC consecutive cycles, `aux_short` becomes 1 in the next cycle. It stays 1 until reset. A run of SHORT_CYC-1 low cycles does not set it.
- R9: While `dim_on` is 0, the short timer stays cleared and cannot set `aux_short`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate | input | 1 | Gate drive state, 1 during on-time |
| zcd_hi | input | 1 | Zero-crossing comparator, 1 when above threshold |
| zsc_hi | input | 1 | Short-detect comparator, 1 when above short threshold |
| dim_on | input | 1 | 1 when the dimming input is above its enable level |
| sw_en | input | 1 | Switching enable; 0 suppresses turn-on requests |
| setpoint | input | SP_W | Current set-point code |
| valley_sel | input | VW | Valley number on which to turn on (1-based) |
| turn_on | output | 1 | One-cycle turn-on request |
| valley_cnt | output | VW | Valleys counted in this off-time |
| light_load | output | 1 | Light-load state with hysteresis |
| aux_short | output | 1 | Sticky auxiliary/output short fault flag |

## Verification
Several crossing patterns are used.

- Blanking boundaries: a crossing placed one cycle before the end of blanking is compared with one placed on the first armed cycle, at both full and halved length. This separates an off-by-one window from a correct one.
- Selection and delay: two clean crossings with a selection of 2 fix the exact cycle of the turn-on pulse. A third crossing then shows that the request is not repeated.
- Time-out: a single crossing followed by a comparator held low shows that the inserted valley arrives exactly one time-out later and completes the selection on its own.
- Short timer: low runs one cycle short of the limit and exactly at it are compared, with and without dimming enabled.

// File: rtl/valley_timer.sv
module valley_timer #(
  parameter int VW          = 4,
  parameter int SP_W        = 8,
  parameter int LIGHT_ENTER = 75,
  parameter int LIGHT_EXIT  = 100,
  parameter int BLANK_CYC   = 160,
  parameter int TIMEOUT_CYC = 650,
  parameter int TURNON_DLY  = 25,
  parameter int SHORT_CYC   = 9000000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gate,
  input  logic            zcd_hi,
  input  logic            zsc_hi,
  input  logic            dim_on,
  input  logic            sw_en,
  input  logic [SP_W-1:0] setpoint,
  input  logic [VW-1:0]   valley_sel,
  output logic            turn_on,
  output logic [VW-1:0]   valley_cnt,
  output logic            light_load,
  output logic            aux_short
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int DW = $clog2(TURNON_DLY + 1);
  localparam int SW = $clog2(SHORT_CYC + 1);
  localparam logic [BW-1:0] BLANK_FULL = BW'(BLANK_CYC);
  localparam logic [BW-1:0] BLANK_HALF = BW'(BLANK_CYC / 2);
  localparam logic [TW-1:0] TMO_LAST   = TW'(TIMEOUT_CYC - 1);
  localparam logic [DW-1:0] DLY_LOAD   = DW'(TURNON_DLY);
  localparam logic [SW-1:0] SC_LAST    = SW'(SHORT_CYC - 1);
  localparam logic [VW-1:0] V_MAX      = {VW{1'b1}};

  logic          gate_d, zcd_d, fired;
  logic [BW-1:0] blank_cnt;
  logic [TW-1:0] tmo_cnt;
  logic [DW-1:0] dly_cnt;
  logic [SW-1:0] sc_cnt;

  wire gate_rise = gate & ~gate_d;
  wire gate_fall = ~gate & gate_d;
  wire armed     = ~gate & ~gate_fall & (blank_cnt == '0);
  wire zfall     = armed & zcd_d & ~zcd_hi;
  wire tmo_hit   = armed & ~zcd_hi & ~zfall & (tmo_cnt == TMO_LAST);
  wire v_evt     = zfall | tmo_hit;
  wire [VW-1:0] v_next = valley_cnt + 1'b1;
  wire sel_hit   = v_evt & ~fired & (valley_cnt != V_MAX) & (v_next == valley_sel);
  wire sc_low    = dim_on & ~zsc_hi;

  assign turn_on = sw_en & (dly_cnt == DW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_d <= 1'b0;
      zcd_d  <= 1'b0;
    end else begin
      gate_d <= gate;
      zcd_d  <= zcd_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               light_load <= 1'b0;
    else if (int'(setpoint) < LIGHT_ENTER) light_load <= 1'b1;
    else if (int'(setpoint) > LIGHT_EXIT)  light_load <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                blank_cnt <= '0;
    else if (gate_fall)        blank_cnt <= light_load ? BLANK_HALF : BLANK_FULL;
    else if (gate)             blank_cnt <= '0;
    else if (blank_cnt != '0)  blank_cnt <= blank_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        tmo_cnt <= '0;
    else if (!armed || zcd_hi || zfall || tmo_hit)     tmo_cnt <= '0;
    else                                               tmo_cnt <= tmo_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valley_cnt <= '0;
      fired      <= 1'b0;
      dly_cnt    <= '0;
    end else if (gate_rise) begin
      valley_cnt <= '0;
      fired      <= 1'b0;
      dly_cnt    <= '0;
    end else begin
      if (v_evt && valley_cnt != V_MAX) valley_cnt <= v_next;
      if (sel_hit) begin
        fired   <= 1'b1;
        dly_cnt <= DLY_LOAD;
      end else if (dly_cnt != '0) begin
        dly_cnt <= dly_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_cnt    <= '0;
      aux_short <= 1'b0;
    end else begin
      if (!sc_low)               sc_cnt <= '0;
      else if (sc_cnt != SC_LAST) sc_cnt <= sc_cnt + 1'b1;
      if (sc_low && sc_cnt == SC_LAST) aux_short <= 1'b1;
    end
  end
endmodule

// File: rtl/valley_timer_chk.sv
module valley_timer_chk #(
  parameter int VW          = 4,
  parameter int SP_W        = 8,
  parameter int LIGHT_ENTER = 75,
  parameter int LIGHT_EXIT  = 100
) (
  input logic            clk,
  input logic            rst_n,
  input logic            gate,
  input logic            dim_on,
  input logic [SP_W-1:0] setpoint,
  input logic            turn_on,
  input logic [VW-1:0]   valley_cnt,
  input logic            light_load,
  input logic            aux_short
);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    turn_on |=> !turn_on);

  a_r6_clear_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |=> valley_cnt == '0);

  a_r1_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(gate) |-> ({1'b0, valley_cnt} <= {1'b0, $past(valley_cnt)} + 1'b1));

  a_r3_enter_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(light_load) |-> int'($past(setpoint)) < LIGHT_ENTER);

  a_r3_leave_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(light_load) |-> int'($past(setpoint)) > LIGHT_EXIT);

  a_r8_sticky_fault: assert property (@(posedge clk) disable iff (!rst_n)
    aux_short |=> aux_short);

  a_r9_dim_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!dim_on && !aux_short) |=> !aux_short);
endmodule

bind valley_timer valley_timer_chk #(
  .VW(VW), .SP_W(SP_W), .LIGHT_ENTER(LIGHT_ENTER), .LIGHT_EXIT(LIGHT_EXIT)
) i_chk (
  .clk(clk), .rst_n(rst_n), .gate(gate), .dim_on(dim_on), .setpoint(setpoint),
  .turn_on(turn_on), .valley_cnt(valley_cnt), .light_load(light_load),
  .aux_short(aux_short)
);

// File: tb/test_valley_timer.sv
module test_valley_timer;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 4, SP_W = 8;
  localparam int BLANK = 8, TMO = 20, DLY = 3, SHORT = 50;

  logic clk = 0, rst_n = 0, gate = 0, zcd_hi = 1, zsc_hi = 1, dim_on = 1, sw_en = 1;
  logic [SP_W-1:0] setpoint = 8'd200;
  logic [VW-1:0]   valley_sel = 4'd2;
  logic turn_on, light_load, aux_short;
  logic [VW-1:0] valley_cnt;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  valley_timer #(.VW(VW), .SP_W(SP_W), .LIGHT_ENTER(75), .LIGHT_EXIT(100),
    .BLANK_CYC(BLANK), .TIMEOUT_CYC(TMO), .TURNON_DLY(DLY), .SHORT_CYC(SHORT))
  i_valley_timer (.clk(clk), .rst_n(rst_n), .gate(gate), .zcd_hi(zcd_hi),
    .zsc_hi(zsc_hi), .dim_on(dim_on), .sw_en(sw_en), .setpoint(setpoint),
    .valley_sel(valley_sel), .turn_on(turn_on), .valley_cnt(valley_cnt),
    .light_load(light_load), .aux_short(aux_short));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_off();
    zcd_hi = 1; gate = 1;
    tick(2);
    gate = 0;
  endtask

  task automatic t_reset();
    check("R1 reset count", valley_cnt, 0);
    check("R5 reset turn_on", turn_on, 0);
    check("R3 reset light_load", light_load, 0);
    check("R8 reset aux_short", aux_short, 0);
  endtask

  task automatic t_blank_full();
    start_off(); tick(BLANK); zcd_hi = 0; tick(1); zcd_hi = 1; tick(2);
    check("R2 crossing in last blank cycle ignored", valley_cnt, 0);
    zcd_hi = 0; tick(1);
    check("R1 crossing counted", valley_cnt, 1);
    start_off(); tick(BLANK + 1); zcd_hi = 0; tick(1);
    check("R2 first armed cycle counts", valley_cnt, 1);
  endtask

  task automatic t_select_delay();
    valley_sel = 2;
    start_off(); tick(BLANK + 2); zcd_hi = 0; tick(1);
    zcd_hi = 1; tick(2); zcd_hi = 0;
    tick(1);
    check("R1 second valley", valley_cnt, 2);
    check("R5 no early pulse", turn_on, 0);
    tick(1); check("R5 no early pulse 2", turn_on, 0);
    tick(1); check("R5 pulse at delay", turn_on, 1);
    tick(1); check("R5 single cycle", turn_on, 0);
    zcd_hi = 1; tick(1); zcd_hi = 0;
    for (int i = 0; i < 6; i++) begin
      tick(1); check("R5 not repeated", turn_on, 0);
    end
    check("R1 third valley", valley_cnt, 3);
  endtask

  task automatic t_timeout();
    valley_sel = 2;
    start_off(); tick(BLANK + 2); zcd_hi = 0;
    tick(TMO);
    check("R4 before time-out", valley_cnt, 1);
    tick(1);
    check("R4 inserted valley", valley_cnt, 2);
    tick(1); check("R4 no pulse yet", turn_on, 0);
    tick(1); check("R4 pulse from inserted valley", turn_on, 1);
  endtask

  task automatic t_light_load();
    setpoint = 50; tick(1);  check("R3 enter", light_load, 1);
    setpoint = 90; tick(2);  check("R3 hold inside band", light_load, 1);
    setpoint = 100; tick(2); check("R3 hold at exit level", light_load, 1);
    setpoint = 101; tick(1); check("R3 leave", light_load, 0);
    setpoint = 80; tick(2);  check("R3 stay off", light_load, 0);
    setpoint = 74; tick(1);  check("R3 re-enter", light_load, 1);
    start_off(); tick(BLANK/2); zcd_hi = 0; tick(1); zcd_hi = 1; tick(2);
    check("R3 halved blank still ignores", valley_cnt, 0);
    start_off(); tick(BLANK/2 + 1); zcd_hi = 0; tick(1);
    check("R3 halved blank ends", valley_cnt, 1);
    gate = 1; tick(1);
    check("R6 rise clears count", valley_cnt, 0);
    setpoint = 200; tick(2);
  endtask

  task automatic t_sw_en();
    sw_en = 0; valley_sel = 1;
    start_off(); tick(BLANK + 2); zcd_hi = 0;
    for (int i = 0; i < 5; i++) begin
      tick(1); check("R7 disabled no request", turn_on, 0);
    end
    sw_en = 1; zcd_hi = 1; valley_sel = 2;
  endtask

  task automatic t_short();
    gate = 1; zcd_hi = 1;
    zsc_hi = 0; tick(SHORT - 1); zsc_hi = 1; tick(2);
    check("R8 one cycle short of limit", aux_short, 0);
    dim_on = 0; zsc_hi = 0; tick(3 * SHORT);
    check("R9 dimmed off, no fault", aux_short, 0);
    dim_on = 1; tick(SHORT - 1);
    check("R8 not yet", aux_short, 0);
    tick(1);
    check("R8 fault raised", aux_short, 1);
    zsc_hi = 1; tick(3);
    check("R8 fault sticky", aux_short, 1);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    t_reset();
    t_blank_full();
    t_select_delay();
    t_timeout();
    t_light_load();
    t_sw_en();
    t_short();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule